// File: doc/BRIEF.md
# Multiplexed 16-bit External Bus Controller

This block sequences external memory and peripheral bus cycles on behalf of a small 8-bit processor core. The core raises a request carrying a direction, a 16-bit address, an accumulator byte and an address-form flag. The block then runs one bus cycle over two multiplexed address/data ports, with an address latch enable pulse and active-low read and write strobes. Each port is modelled as separate output, output-enable and input signals, so the pad ring decides how they are tied together.

A wide-mode configuration bit turns each transfer into a 16-bit one for IDE/ATAPI-style devices. In wide mode the low byte travels through the accumulator path and the high byte through a holding register that the block owns. The core can load that register, and wide reads capture into it. A stretch bit widens the strobe so that slow devices can respond. Where the high address byte comes from depends on the address form and on a page-access disable bit.

Top module: `xbus16_ctrl`

## Requirements
- R1: After reset and whenever idle: `ale`=0, `rd_n`=1, `wr_n`=1, `lo_oe`=0, `hi_oe`=0, `busy`=0, `done`=0, and `hi_q`=0 after reset.
- R2: A request seen with `req_valid`=1 on a clock edge while `busy`=0 is accepted. `busy` is high for exactly S+3 clocks, starting in the clock after acceptance, where S is the strobe width. `req_valid` while `busy`=1 is ignored and has no effect on that cycle's pins.
- R3: Clock 0 of a cycle has `ale`=1. Clock 1 has `ale`=0. In both clocks both ports are driven with the address: `lo_out`=A[7:0] and `hi_out`=the high address byte.
- R4: The strobe is low in clocks 2 through S+1, where S=3, or S=15 when the stretch bit is 1. It is `rd_n` when `req_write`=0 and `wr_n` when `req_write`=1. The two strobes are never low together.
- R5: On a write, from clock 2 to the end of the cycle, `lo_out` carries `acc_wdata` with `lo_oe`=1. In wide mode `hi_out` carries the high holding register value that was current at acceptance, with `hi_oe`=1.
- R6: On a read, `lo_oe`=0 from clock 2 to the end of the cycle. `rd_data` takes `lo_in` as sampled on the clock edge that ends clock S+1, which is the last strobe-low clock.
- R7: On a wide read, `hi_q` takes `hi_in` at that same edge. In narrow mode `hi_q` is not changed by any cycle, and `hi_out` keeps the high address byte driven (`hi_oe`=1) for the whole cycle.
- R8: The high address byte is `p2_latch` when `req_short_addr`=1 or `cfg_page_dis`=1. Otherwise it is `req_addr[15:8]`.
- R9: `hi_load`=1 writes `hi_load_data` into `hi_q` on the next edge. A capture from a wide read takes priority on the same edge.
- R10: `done` is high for exactly one clock, the last clock of the cycle (clock S+2).
- R11: The wide, stretch and page configuration bits, the address, the accumulator byte and the high register value are all sampled at acceptance. Changes to them during a cycle do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_short_addr | input | 1 | 1 = 8-bit register-indirect address form |
| req_addr | input | 16 | Transfer address |
| acc_wdata | input | 8 | Accumulator byte (low write data) |
| p2_latch | input | 8 | Value of the high port output latch |
| cfg_wide | input | 1 | 16-bit transfer mode |
| cfg_stretch | input | 1 | Long strobe (15 clocks) |
| cfg_page_dis | input | 1 | Page access: high port shows latch instead of pointer high byte |
| hi_load | input | 1 | Load high holding register |
| hi_load_data | input | 8 | Data for high holding register |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | Last clock of a cycle |
| rd_data | output | 8 | Low read byte (accumulator path) |
| hi_q | output | 8 | High holding register |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| lo_out | output | 8 | Low port output value |
| lo_oe | output | 1 | Low port output enable |
| lo_in | input | 8 | Low port input value |
| hi_out | output | 8 | High port output value |
| hi_oe | output | 1 | High port output enable |
| hi_in | input | 8 | High port input value |

## Verification
The sequence position is a single counter, so a counter that is off by one shifts a whole phase. The ALE pulse, the strobe edge and `done` then move by one clock within the same cycle, and the next check at the pins catches it. A wrong capture edge does not show during the cycle. It appears only after the cycle ends, as a wrong `rd_data` or `hi_q`, because the bench drives the correct read data on the sampling clock only. Request fields that are not latched fail in the cycle that follows a mid-cycle change to the inputs.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  parameter int unsigned XB_BYTE = 8;

  typedef struct packed {
    logic               write;
    logic               wide;
    logic               stretch;
    logic [XB_BYTE-1:0] addr_hi;
    logic [XB_BYTE-1:0] addr_lo;
    logic [XB_BYTE-1:0] wdata_lo;
    logic [XB_BYTE-1:0] wdata_hi;
  } xbus_req_t;
endpackage

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter int unsigned CNT_W        = 5,
  parameter int unsigned STROBE_SHORT = 3,
  parameter int unsigned STROBE_LONG  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  xbus_req_t        new_req,
  output logic             busy_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             busy_d,
  output logic [CNT_W-1:0] cnt_d,
  output xbus_req_t        req_d,
  output logic             cur_write,
  output logic             cur_wide,
  output logic             cur_stretch
);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(STROBE_SHORT + 2);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(STROBE_LONG + 2);

  xbus_req_t        req_q;
  logic [CNT_W-1:0] last_k;
  logic             accept;

  assign last_k = req_q.stretch ? LAST_L : LAST_S;
  assign accept = req_valid && !busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    req_d  = req_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      req_d  = new_req;
    end else if (busy_q) begin
      if (cnt_q == last_k) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      req_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      req_q  <= req_d;
    end
  end

  assign cur_write   = req_q.write;
  assign cur_wide    = req_q.wide;
  assign cur_stretch = req_q.stretch;

  // R2 R11
  req_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> (req_q == $past(req_q)));

endmodule

// File: rtl/xbus_pin_stage.sv
module xbus_pin_stage
  import xbus_pkg::*;
#(
  parameter int unsigned CNT_W        = 5,
  parameter int unsigned STROBE_SHORT = 3,
  parameter int unsigned STROBE_LONG  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busy_d,
  input  logic [CNT_W-1:0]   cnt_d,
  input  xbus_req_t          req_d,
  output logic               ale,
  output logic               rd_n,
  output logic               wr_n,
  output logic               done,
  output logic [XB_BYTE-1:0] lo_out,
  output logic               lo_oe,
  output logic [XB_BYTE-1:0] hi_out,
  output logic               hi_oe
);
  localparam logic [CNT_W-1:0] DATA_K = CNT_W'(2);
  localparam logic [CNT_W-1:0] END_S  = CNT_W'(STROBE_SHORT + 1);
  localparam logic [CNT_W-1:0] END_L  = CNT_W'(STROBE_LONG + 1);
  localparam logic [CNT_W-1:0] LAST_S = CNT_W'(STROBE_SHORT + 2);
  localparam logic [CNT_W-1:0] LAST_L = CNT_W'(STROBE_LONG + 2);

  logic [CNT_W-1:0] end_k, last_k;
  logic             addr_ph, strobe, final_k;

  always_comb begin
    end_k   = req_d.stretch ? END_L : END_S;
    last_k  = req_d.stretch ? LAST_L : LAST_S;
    addr_ph = busy_d && (cnt_d < DATA_K);
    strobe  = busy_d && (cnt_d >= DATA_K) && (cnt_d <= end_k);
    final_k = busy_d && (cnt_d == last_k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      done   <= 1'b0;
      lo_oe  <= 1'b0;
      hi_oe  <= 1'b0;
      lo_out <= '0;
      hi_out <= '0;
    end else begin
      ale   <= busy_d && (cnt_d == '0);
      rd_n  <= !(strobe && !req_d.write);
      wr_n  <= !(strobe && req_d.write);
      done  <= final_k;
      lo_oe <= addr_ph || (busy_d && req_d.write);
      hi_oe <= addr_ph || (busy_d && (req_d.write || !req_d.wide));
      if (!busy_d)                    lo_out <= '0;
      else if (addr_ph)               lo_out <= req_d.addr_lo;
      else if (req_d.write)           lo_out <= req_d.wdata_lo;
      else                            lo_out <= '0;
      if (!busy_d)                    hi_out <= '0;
      else if (addr_ph || !req_d.wide) hi_out <= req_d.addr_hi;
      else if (req_d.write)           hi_out <= req_d.wdata_hi;
      else                            hi_out <= '0;
    end
  end

  // strobe run-length checker
  logic             strobe_lo;
  logic             run_stretch;
  logic [CNT_W-1:0] low_run;
  assign strobe_lo = !rd_n || !wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run     <= '0;
      run_stretch <= 1'b0;
    end else begin
      run_stretch <= req_d.stretch;
      low_run     <= strobe_lo ? low_run + 1'b1 : '0;
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobe_lo && $past(strobe_lo)) |->
      (low_run == (run_stretch ? CNT_W'(STROBE_LONG) : CNT_W'(STROBE_SHORT))));

  // R3
  ale_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && $stable(lo_out) && $stable(hi_out) && lo_oe && hi_oe));

endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
  import xbus_pkg::*;
#(
  parameter int unsigned CNT_W        = 5,
  parameter int unsigned STROBE_SHORT = 3,
  parameter int unsigned STROBE_LONG  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busy_q,
  input  logic [CNT_W-1:0]   cnt_q,
  input  logic               cur_write,
  input  logic               cur_wide,
  input  logic               cur_stretch,
  input  logic [XB_BYTE-1:0] lo_in,
  input  logic [XB_BYTE-1:0] hi_in,
  input  logic               hi_load,
  input  logic [XB_BYTE-1:0] hi_load_data,
  output logic [XB_BYTE-1:0] rd_data,
  output logic [XB_BYTE-1:0] hi_q
);
  localparam logic [CNT_W-1:0] END_S = CNT_W'(STROBE_SHORT + 1);
  localparam logic [CNT_W-1:0] END_L = CNT_W'(STROBE_LONG + 1);

  logic sample;
  assign sample = busy_q && !cur_write &&
                  (cnt_q == (cur_stretch ? END_L : END_S));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      hi_q    <= '0;
    end else begin
      if (sample) rd_data <= lo_in;
      if (sample && cur_wide) hi_q <= hi_in;
      else if (hi_load)       hi_q <= hi_load_data;
    end
  end

  // R7 R9
  hi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> ($stable(hi_q) || $past(hi_load)));

endmodule

// File: rtl/xbus16_ctrl.sv
module xbus16_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned STROBE_SHORT = 3,
  parameter int unsigned STROBE_LONG  = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_short_addr,
  input  logic [2*XB_BYTE-1:0] req_addr,
  input  logic [XB_BYTE-1:0] acc_wdata,
  input  logic [XB_BYTE-1:0] p2_latch,
  input  logic               cfg_wide,
  input  logic               cfg_stretch,
  input  logic               cfg_page_dis,
  input  logic               hi_load,
  input  logic [XB_BYTE-1:0] hi_load_data,
  output logic               busy,
  output logic               done,
  output logic [XB_BYTE-1:0] rd_data,
  output logic [XB_BYTE-1:0] hi_q,
  output logic               ale,
  output logic               rd_n,
  output logic               wr_n,
  output logic [XB_BYTE-1:0] lo_out,
  output logic               lo_oe,
  input  logic [XB_BYTE-1:0] lo_in,
  output logic [XB_BYTE-1:0] hi_out,
  output logic               hi_oe,
  input  logic [XB_BYTE-1:0] hi_in
);
  localparam int unsigned CNT_W = $clog2(STROBE_LONG + 3);

  xbus_req_t        new_req, req_d;
  logic             busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cur_write, cur_wide, cur_stretch;

  always_comb begin
    new_req.write    = req_write;
    new_req.wide     = cfg_wide;
    new_req.stretch  = cfg_stretch;
    new_req.addr_hi  = (req_short_addr || cfg_page_dis) ? p2_latch
                                                        : req_addr[2*XB_BYTE-1:XB_BYTE];
    new_req.addr_lo  = req_addr[XB_BYTE-1:0];
    new_req.wdata_lo = acc_wdata;
    new_req.wdata_hi = hi_q;
  end

  xbus_sequencer #(.CNT_W(CNT_W), .STROBE_SHORT(STROBE_SHORT), .STROBE_LONG(STROBE_LONG)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .new_req(new_req),
    .busy_q(busy), .cnt_q(cnt_q), .busy_d(busy_d), .cnt_d(cnt_d), .req_d(req_d),
    .cur_write(cur_write), .cur_wide(cur_wide), .cur_stretch(cur_stretch)
  );

  xbus_pin_stage #(.CNT_W(CNT_W), .STROBE_SHORT(STROBE_SHORT), .STROBE_LONG(STROBE_LONG)) u_pins (
    .clk(clk), .rst(rst), .busy_d(busy_d), .cnt_d(cnt_d), .req_d(req_d),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .done(done),
    .lo_out(lo_out), .lo_oe(lo_oe), .hi_out(hi_out), .hi_oe(hi_oe)
  );

  xbus_capture #(.CNT_W(CNT_W), .STROBE_SHORT(STROBE_SHORT), .STROBE_LONG(STROBE_LONG)) u_cap (
    .clk(clk), .rst(rst), .busy_q(busy), .cnt_q(cnt_q),
    .cur_write(cur_write), .cur_wide(cur_wide), .cur_stretch(cur_stretch),
    .lo_in(lo_in), .hi_in(hi_in), .hi_load(hi_load), .hi_load_data(hi_load_data),
    .rd_data(rd_data), .hi_q(hi_q)
  );

  // busy run-length checker
  logic [CNT_W-1:0] busy_run;
  always_ff @(posedge clk) begin
    if (rst) busy_run <= '0;
    else     busy_run <= busy ? busy_run + 1'b1 : '0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |->
      (busy_run == (cur_stretch ? CNT_W'(STROBE_LONG + 3) : CNT_W'(STROBE_SHORT + 3))));

  // R3
  busy_ale_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ale);

  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !lo_oe);

  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && !done));

endmodule

// File: tb/xbus16_ctrl_bench.sv
module xbus16_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_short_addr = 0;
  logic [15:0] req_addr = 0;
  logic [7:0]  acc_wdata = 0, p2_latch = 0;
  logic        cfg_wide = 0, cfg_stretch = 0, cfg_page_dis = 0;
  logic        hi_load = 0;
  logic [7:0]  hi_load_data = 0;
  logic [7:0]  lo_in = 0, hi_in = 0;
  logic        busy, done, ale, rd_n, wr_n, lo_oe, hi_oe;
  logic [7:0]  rd_data, hi_q, lo_out, hi_out;

  xbus16_ctrl u_xbus16_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_short_addr(req_short_addr), .req_addr(req_addr), .acc_wdata(acc_wdata),
    .p2_latch(p2_latch), .cfg_wide(cfg_wide), .cfg_stretch(cfg_stretch),
    .cfg_page_dis(cfg_page_dis), .hi_load(hi_load), .hi_load_data(hi_load_data),
    .busy(busy), .done(done), .rd_data(rd_data), .hi_q(hi_q), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in),
    .hi_out(hi_out), .hi_oe(hi_oe), .hi_in(hi_in)
  );

  int   total = 0;
  int   bad = 0;
  logic finished = 0;
  logic [7:0] hmod = 0;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    logic [6:0] a, e;
    a = {busy, ale, rd_n, wr_n, lo_oe, hi_oe, done};
    e = 7'b0011000;
    check(a == e, tag, 32'(a), 32'(e));
  endtask

  task automatic load_hi(input logic [7:0] v);
    hi_load = 1; hi_load_data = v;
    @(posedge clk); @(negedge clk);
    hi_load = 0;
    hmod = v;
    check(hi_q == v, "R9 hi load", 32'(hi_q), 32'(v));
  endtask

  task automatic run_txn(input logic wr, input logic wide, input logic str,
                         input logic sh, input logic pg, input logic [15:0] addr,
                         input logic [7:0] acc, input logic [7:0] p2v,
                         input logic [7:0] rlo, input logic [7:0] rhi,
                         input logic hold);
    int          sw, len;
    logic [7:0]  hiaddr, hsnap;
    sw     = str ? 15 : 3;
    len    = sw + 3;
    hiaddr = (sh || pg) ? p2v : addr[15:8];
    hsnap  = hmod;
    req_write = wr; cfg_wide = wide; cfg_stretch = str; req_short_addr = sh;
    cfg_page_dis = pg; req_addr = addr; acc_wdata = acc; p2_latch = p2v;
    req_valid = 1;
    @(posedge clk); @(negedge clk);
    for (int k = 0; k < len; k++) begin
      logic       stb, lo_oe_e, hi_oe_e;
      logic [7:0] lo_e, hi_e, lo_a, hi_a;
      logic [6:0] ca, ce;
      if (k == 0 && !hold) req_valid = 0;
      if (k == 1) begin
        cfg_wide = ~wide; cfg_stretch = ~str; cfg_page_dis = ~pg;
        req_short_addr = ~sh; req_addr = ~addr; acc_wdata = ~acc; p2_latch = ~p2v;
        hi_load = 0;
      end
      if (k == len - 1) req_valid = 0;
      lo_in = (k == sw + 1) ? rlo : ~rlo;
      hi_in = (k == sw + 1) ? rhi : ~rhi;
      stb     = (k >= 2) && (k <= sw + 1);
      lo_oe_e = (k < 2) || wr;
      hi_oe_e = (k < 2) || !wide || wr;
      lo_e    = (k < 2) ? addr[7:0] : acc;
      hi_e    = ((k < 2) || !wide) ? hiaddr : hsnap;
      ca = {busy, ale, rd_n, wr_n, lo_oe, hi_oe, done};
      ce = {1'b1, k == 0, !(stb && !wr), !(stb && wr), lo_oe_e, hi_oe_e, k == len - 1};
      // R2 R3 R4 R10 R11: control pins per clock
      check(ca == ce, "R2 R3 R4 R10 R11 control", 32'(ca), 32'(ce));
      lo_a = lo_oe_e ? lo_out : 8'h00;
      hi_a = hi_oe_e ? hi_out : 8'h00;
      if (k < 2) begin
        check({lo_a, hi_a} == {lo_e, hi_e}, "R3 R8 address", 32'({lo_a, hi_a}), 32'({lo_e, hi_e}));
      end else if (wr) begin
        check({lo_a, hi_a} == {lo_e, hi_e}, "R5 R11 write data", 32'({lo_a, hi_a}), 32'({lo_e, hi_e}));
      end else begin
        check({lo_a, hi_a} == {8'h00, wide ? 8'h00 : hi_e}, "R6 R7 read drive",
              32'({lo_a, hi_a}), 32'({8'h00, wide ? 8'h00 : hi_e}));
      end
      @(posedge clk); @(negedge clk);
    end
    check_idle("R1 R2 idle after cycle");
    if (!wr) begin
      check(rd_data == rlo, "R6 read sample", 32'(rd_data), 32'(rlo));
      if (wide) hmod = rhi;
    end
    check(hi_q == hmod, "R7 high register", 32'(hi_q), 32'(hmod));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1 reset");
    rst = 0;
    @(posedge clk); @(negedge clk);
    check_idle("R1 after release");
    check(hi_q == 8'h00, "R1 hi reset", 32'(hi_q), 32'h0);
    for (int c = 0; c < 64; c++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = c[5] ? (16'hA5C3 ^ 16'(c * 257)) : (16'h1234 + 16'(c * 97));
      d = 8'(c * 37 + 11);
      if (c % 4 == 0) load_hi(8'(8'h5A ^ c));
      run_txn(c[0], c[1], c[2], c[3], c[4], a, d, 8'(d ^ 8'hC6),
              8'(d + 8'h3D), 8'(d ^ 8'h99), c[5]);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule